// File: doc/BRIEF.md
# Bit-Budget Coefficient Quantizer

This block reduces the precision of a stream of signed 2-D transform coefficients belonging to 8x8 blocks. It does not divide. Each of the 64 block positions has a programmable bit budget: the number of magnitude bits that position keeps. An incoming coefficient arrives as a sign bit and a 16-bit magnitude. Its magnitude is shifted right until only the budgeted bits remain, and the sign is then put back. The largest magnitude a transform stage produces is 65280. The output is registered and carries the coefficient's position index through unchanged.

The budgets are held twice. A pending copy takes writes from outside at any time. An active copy is used for quantizing. The pending copy becomes active only when a coefficient flagged as the first of a block is accepted, so a block is always quantized with one consistent table.

A small controller has two states. `ST_IDLE` means no block is open. `ST_BLOCK` means a block is open and coefficients are being accepted. The transitions are:
- `ST_IDLE` to `ST_BLOCK`: a first-of-block coefficient arrives.
- `ST_BLOCK` to `ST_BLOCK`: a first-of-block coefficient arrives, which restarts the block, or an ordinary coefficient arrives before the 64th.
- `ST_BLOCK` to `ST_IDLE`: the 64th coefficient of the block is accepted.

In `ST_IDLE`, coefficients without the first-of-block flag are dropped.

Top module: `coef_shift_quant`

## Requirements
- R1: After reset, `out_valid` is low, the controller is in `ST_IDLE`, and every budget in both copies is 0.
- R2: A write with `tbl_we` high stores `tbl_keep` (4 bits) into the pending budget for position `tbl_addr` (6 bits, 64 positions).
- R3: For a budget k from 1 to 15, the output magnitude is the input magnitude shifted right by 16 minus k, which keeps its top k of 16 bits.
- R4: A budget of 0 gives an output magnitude of 0 for any input.
- R5: `in_sign`/`out_sign` use 1 for negative. A non-zero result keeps the input sign. A zero result always has `out_sign` 0. Negative values therefore truncate toward zero.
- R6: An accepted coefficient appears on the output exactly one clock later, with `out_valid` high and `out_pos` equal to its `in_pos`.
- R7: An accepted coefficient with `in_first` high makes the pending table active. That coefficient is itself quantized with the newly adopted budgets.
- R8: Table writes made while a block is open do not change the budgets used by later coefficients of that block. They apply from the next first-of-block coefficient.
- R9: A coefficient with `in_first` low is dropped (no `out_valid`) when no block is open. This covers the time after reset and the time after 64 coefficients of a block have been accepted.
- R10: A first-of-block coefficient arriving while a block is open restarts the block. It resets the 64-coefficient count and adopts the pending table.
- R11: With `in_valid` low, `in_first` is ignored: no output is produced and no block opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_we | input | 1 | Budget table write strobe |
| tbl_addr | input | 6 | Position written |
| tbl_keep | input | 4 | Bits to keep for that position |
| in_valid | input | 1 | Input coefficient valid |
| in_first | input | 1 | Coefficient is the first of a block |
| in_pos | input | 6 | Position index of the coefficient |
| in_sign | input | 1 | Sign, 1 = negative |
| in_mag | input | 16 | Magnitude |
| out_valid | output | 1 | Quantized coefficient valid |
| out_pos | output | 6 | Position index passed through |
| out_sign | output | 1 | Sign of result, 0 when result is zero |
| out_mag | output | 16 | Quantized magnitude |

## Verification
The shifting path is driven with magnitudes at the full-scale peak, at single-bit and all-ones patterns, and at values just below a power of two. Each of these is run with budgets of 0, 1, mid-range and 15. Together they separate a shift that is off by one, a lost sign, a negative zero and an inverted budget. Each vector opens its own block after writing its budget, which shows whether the first coefficient uses the freshly adopted table. Directed sequences write budgets in the middle of a block, restart a block early, run past 64 coefficients, and pulse the first-of-block flag with no valid coefficient, to tell the two table copies and the block counter apart.

// File: rtl/qz_pkg.sv
package qz_pkg;
    localparam int MAG_W  = 16;
    localparam int KEEP_W = 4;
    localparam int POS_W  = 6;
    localparam int NPOS   = 1 << POS_W;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BLOCK = 1'b1
    } blk_state_t;
endpackage

// File: rtl/qz_keep_table.sv
module qz_keep_table
    import qz_pkg::*;
#(
    parameter int PW = POS_W,
    parameter int KW = KEEP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_pos,
    input  logic [KW-1:0] wr_keep,
    input  logic          adopt,
    input  logic [PW-1:0] lk_pos,
    output logic [KW-1:0] keep_o
);
    localparam int N = 1 << PW;

    logic [N-1:0][KW-1:0] pend_q;
    logic [N-1:0][KW-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (wr_en) begin
            pend_q[wr_pos] <= wr_keep;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (adopt) begin
            act_q <= pend_q;
        end
    end

    always_comb begin
        keep_o = adopt ? pend_q[lk_pos] : act_q[lk_pos];
    end

    // R8
    frozen_table_chk: assert property (@(posedge clk) disable iff (rst)
        !adopt |=> $stable(act_q));

    // R7
    adopted_entry_chk: assert property (@(posedge clk) disable iff (rst)
        adopt |=> act_q[$past(lk_pos)] == $past(keep_o));
endmodule

// File: rtl/qz_blk_fsm.sv
module qz_blk_fsm
    import qz_pkg::*;
#(
    parameter int PW = POS_W
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_first,
    output logic accept,
    output logic adopt,
    output logic open_o
);
    localparam int N = 1 << PW;
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    blk_state_t    state_q, state_d;
    logic [PW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        adopt   = 1'b0;
        open_o  = (state_q == ST_BLOCK);
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_first) begin
                    accept  = 1'b1;
                    adopt   = 1'b1;
                    state_d = ST_BLOCK;
                    cnt_d   = PW'(1);
                end
            end
            ST_BLOCK: begin
                if (in_valid && in_first) begin
                    accept  = 1'b1;
                    adopt   = 1'b1;
                    cnt_d   = PW'(1);
                end else if (in_valid) begin
                    accept = 1'b1;
                    if (cnt_q == LAST) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + PW'(1);
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // R9
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !in_first) |-> !accept);

    // R11
    no_valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (state_q == $past(state_q)) && $stable(cnt_q));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_first) |=> (state_q == ST_BLOCK) && (cnt_q == PW'(1)));
endmodule

// File: rtl/qz_shift_unit.sv
module qz_shift_unit
    import qz_pkg::*;
#(
    parameter int MW = MAG_W,
    parameter int KW = KEEP_W,
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [KW-1:0] keep,
    input  logic [PW-1:0] pos,
    input  logic          sign,
    input  logic [MW-1:0] mag,
    output logic          out_valid,
    output logic [PW-1:0] out_pos,
    output logic          out_sign,
    output logic [MW-1:0] out_mag
);
    localparam int SH_W = $clog2(MW + 1);

    logic [SH_W-1:0] sh_amt;
    logic [MW-1:0]   shifted;

    always_comb begin
        sh_amt  = SH_W'(MW) - SH_W'(keep);
        shifted = (keep == '0) ? '0 : (mag >> sh_amt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pos   <= '0;
            out_sign  <= 1'b0;
            out_mag   <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_pos  <= pos;
                out_mag  <= shifted;
                out_sign <= sign & (|shifted);
            end
        end
    end

    // R5
    no_neg_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mag == '0) |-> !out_sign);

    // R3
    no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_mag <= $past(mag));

    // R6
    pos_through_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_pos == $past(pos));

    // R6
    one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> out_valid);
endmodule

// File: rtl/coef_shift_quant.sv
module coef_shift_quant
    import qz_pkg::*;
#(
    parameter int MW = MAG_W,
    parameter int KW = KEEP_W,
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tbl_we,
    input  logic [PW-1:0] tbl_addr,
    input  logic [KW-1:0] tbl_keep,
    input  logic          in_valid,
    input  logic          in_first,
    input  logic [PW-1:0] in_pos,
    input  logic          in_sign,
    input  logic [MW-1:0] in_mag,
    output logic          out_valid,
    output logic [PW-1:0] out_pos,
    output logic          out_sign,
    output logic [MW-1:0] out_mag
);
    logic          accept;
    logic          adopt;
    logic          blk_open;
    logic [KW-1:0] keep;

    qz_blk_fsm #(.PW(PW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_first (in_first),
        .accept   (accept),
        .adopt    (adopt),
        .open_o   (blk_open)
    );

    qz_keep_table #(.PW(PW), .KW(KW)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we),
        .wr_pos  (tbl_addr),
        .wr_keep (tbl_keep),
        .adopt   (adopt),
        .lk_pos  (in_pos),
        .keep_o  (keep)
    );

    qz_shift_unit #(.MW(MW), .KW(KW), .PW(PW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .fire      (accept),
        .keep      (keep),
        .pos       (in_pos),
        .sign      (in_sign),
        .mag       (in_mag),
        .out_valid (out_valid),
        .out_pos   (out_pos),
        .out_sign  (out_sign),
        .out_mag   (out_mag)
    );

    // R11
    idle_input_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    closed_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!blk_open && in_valid && !in_first) |=> !out_valid);
endmodule

// File: tb/sim_coef_shift_quant.sv
`timescale 1ns/1ps
module sim_coef_shift_quant;
    logic        clk = 1'b0;
    logic        rst;
    logic        tbl_we;
    logic [5:0]  tbl_addr;
    logic [3:0]  tbl_keep;
    logic        in_valid, in_first, in_sign;
    logic [5:0]  in_pos;
    logic [15:0] in_mag;
    logic        out_valid, out_sign;
    logic [5:0]  out_pos;
    logic [15:0] out_mag;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    coef_shift_quant u0 (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_keep(tbl_keep), .in_valid(in_valid), .in_first(in_first),
        .in_pos(in_pos), .in_sign(in_sign), .in_mag(in_mag),
        .out_valid(out_valid), .out_pos(out_pos), .out_sign(out_sign),
        .out_mag(out_mag)
    );

    // {pos, keep, sign, mag, exp_sign, exp_mag}
    localparam logic [43:0] VEC [10] = '{
        {6'd0,  4'd8,  1'b0, 16'hFF00, 1'b0, 16'h00FF},
        {6'd7,  4'd8,  1'b1, 16'hFF00, 1'b1, 16'h00FF},
        {6'd9,  4'd15, 1'b1, 16'h0003, 1'b1, 16'h0001},
        {6'd63, 4'd15, 1'b1, 16'h0001, 1'b0, 16'h0000},
        {6'd31, 4'd0,  1'b1, 16'hFFFF, 1'b0, 16'h0000},
        {6'd1,  4'd1,  1'b0, 16'h8000, 1'b0, 16'h0001},
        {6'd2,  4'd1,  1'b0, 16'h7FFF, 1'b0, 16'h0000},
        {6'd40, 4'd4,  1'b1, 16'h1234, 1'b1, 16'h0001},
        {6'd62, 4'd12, 1'b0, 16'hABCD, 1'b0, 16'h0ABC},
        {6'd5,  4'd10, 1'b1, 16'h0400, 1'b1, 16'h0010}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_tbl(input logic [5:0] a, input logic [3:0] k);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = a; tbl_keep = k;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic send(input logic v, input logic f, input logic [5:0] p,
                        input logic s, input logic [15:0] m);
        @(negedge clk);
        in_valid = v; in_first = f; in_pos = p; in_sign = s; in_mag = m;
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nvec++; nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tbl_we = 1'b0; tbl_addr = '0; tbl_keep = '0;
        in_valid = 1'b0; in_first = 1'b0; in_pos = '0; in_sign = 1'b0; in_mag = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);

        // R9: no block open after reset -> dropped
        send(1'b1, 1'b0, 6'd3, 1'b0, 16'hFFFF);
        chk("R9 drop before block", {31'd0, out_valid}, 32'd0);

        // R1: untouched table is all zero budgets
        send(1'b1, 1'b1, 6'd3, 1'b1, 16'hFFFF);
        chk("R1 zero table valid", {31'd0, out_valid}, 32'd1);
        chk("R1 zero table result", {15'd0, out_sign, out_mag}, 32'd0);

        // Vector table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 10; i++) begin
            wr_tbl(VEC[i][43:38], VEC[i][37:34]);
            send(1'b1, 1'b1, VEC[i][43:38], VEC[i][33], VEC[i][32:17]);
            chk("R6 valid", {31'd0, out_valid}, 32'd1);
            chk("R6 pos", {26'd0, out_pos}, {26'd0, VEC[i][43:38]});
            chk("R3/R4/R5 result", {15'd0, out_sign, out_mag}, {15'd0, VEC[i][16:0]});
        end

        // R8: a mid-block write is not seen until the next block
        wr_tbl(6'd10, 4'd8);
        send(1'b1, 1'b1, 6'd10, 1'b0, 16'hFF00);
        chk("R7 first uses new table", {16'd0, out_mag}, 32'h00FF);
        wr_tbl(6'd11, 4'd12);
        send(1'b1, 1'b0, 6'd11, 1'b0, 16'hFF00);
        chk("R8 write held back valid", {31'd0, out_valid}, 32'd1);
        chk("R8 write held back", {16'd0, out_mag}, 32'h0000);

        // R10: restart mid-block adopts the pending write
        send(1'b1, 1'b1, 6'd11, 1'b0, 16'hFF00);
        chk("R10 restart adopts", {16'd0, out_mag}, 32'h0FF0);

        // R9: 63 more coefficients close the block, the next is dropped
        for (int j = 0; j < 63; j++) begin
            send(1'b1, 1'b0, 6'(j), 1'b0, 16'h0100);
            if (j == 62) chk("R10 64th accepted", {31'd0, out_valid}, 32'd1);
        end
        send(1'b1, 1'b0, 6'd11, 1'b0, 16'hFF00);
        chk("R9 drop after 64", {31'd0, out_valid}, 32'd0);

        // R11: in_first without in_valid does nothing
        send(1'b0, 1'b1, 6'd11, 1'b0, 16'hFF00);
        chk("R11 no output", {31'd0, out_valid}, 32'd0);
        send(1'b1, 1'b0, 6'd11, 1'b0, 16'hFF00);
        chk("R11 no block opened", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule